// File: doc/BRIEF.md
# Receive Character Queue with Threshold and Idle Timeout

This block holds characters that a serial receiver has assembled until software reads them. The line side offers one byte per push. The register side takes one byte per pop, and the byte appears on the read-data output in the cycle after the pop. The queue reports its state on three flags: nothing stored, no room left, and at or above a programmable threshold. It pulses an overrun event when a byte arrives with no room for it. It also watches the line for silence. A character-time tick, produced elsewhere at one pulse per character period, drives a counter that restarts on every stored byte. After four ticks with no new byte, the block pulses a timeout event.

The receiver is enabled by one control and blocked by a second control. The blocking control wins when both are set. While the receiver is not enabled, pushes and pops have no effect. A one-cycle flush pulse discards the queue contents and stops the idle timer.

Top module: `rxq_top`

## Requirements
- R1: The queue holds up to 16 bytes and returns them in arrival order. A pop at a clock edge places the oldest byte on `rd_data` one cycle later. `rd_data` keeps its value until the next effective pop.
- R2: A push while 16 bytes are stored and no pop occurs in the same cycle is dropped. It pulses `overrun` high for exactly one cycle, in the cycle after the push.
- R3: After every effective push, pop or flush, `trig` equals (occupancy >= `trig_level`), where `trig_level` is an unsigned 6-bit value. `trig` holds its value between such operations.
- R4: `full` is 1 exactly when 16 bytes are stored. A pop alone always clears it.
- R5: `empty` is 1 exactly when no byte is stored. A push clears it, and a pop that takes the last byte sets it.
- R6: A pop on an empty queue places 0x00 on `rd_data` and leaves `empty` at 1.
- R7: Push and pop take effect only while `rx_en`=1 and `rx_dis`=0. With `rx_dis`=1 the flags, `rd_data` and the stored contents stay unchanged, whatever `rx_en` is.
- R8: Each stored byte restarts the idle timer. The fourth `char_tick` after the restart, with no byte stored in between, pulses `timeout` for one cycle, in the cycle after that tick. The timer then stays idle until the next stored byte.
- R9: `rx_flush` empties the queue, sets `empty`, clears `full` and stops the idle timer. A push or pop in the same cycle is ignored.
- R10: After reset `empty`=1, `full`=0, `trig`=0, `rd_data`=0, and neither event fires. With a threshold of 32, `trig` stays 0 even when the queue is full.
- R11: A push and a pop in the same cycle on a non-empty queue return the oldest byte, store the new byte and leave the occupancy unchanged. This applies even when the queue is full, and no overrun occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable |
| rx_dis | input | 1 | Receiver block; overrides rx_en |
| rx_flush | input | 1 | One-cycle queue flush |
| char_tick | input | 1 | One pulse per character period |
| trig_level | input | 6 | Threshold for the trig flag |
| push_valid | input | 1 | Received byte offered |
| push_data | input | 8 | Received byte |
| pop | input | 1 | Read strobe from the register side |
| rd_data | output | 8 | Byte returned by the last effective pop |
| empty | output | 1 | No byte stored |
| full | output | 1 | 16 bytes stored |
| trig | output | 1 | Occupancy at or above threshold |
| overrun | output | 1 | Pulse: byte dropped for lack of room |
| timeout | output | 1 | Pulse: four character times without a new byte |

## Verification
Push and pop can land in the same cycle, and that collision carries the risk. The bench forces it on an empty queue, on a partly filled queue and on a full queue. A behavioural queue model judges each case on the returned byte, the flags and whether an overrun is reported. A stored byte and a character tick can also coincide. The bench pairs them at the moment the idle count would expire and expects the restart to win, so no timeout pulse follows. A long pseudo-random phase then mixes pushes, pops, ticks, blocking and flushes. Every output is compared against the model on every clock.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    // Kind of queue access in one cycle: {push, pop}
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_BOTH = 2'b11
    } rxq_op_e;

    localparam int RXQ_DEPTH    = 16;
    localparam int RXQ_DW       = 8;
    localparam int RXQ_LVLW     = 6;
    localparam int RXQ_TO_CHARS = 4;
endpackage

// File: rtl/rxq_mem.sv
module rxq_mem #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && waddr == AW'(g)) begin
                slot_q[g] <= wdata;
            end
        end
    end

    assign rdata = slot_q[raddr];
endmodule

// File: rtl/rxq_tmo.sv
module rxq_tmo #(
    parameter int TO_CHARS = 4,
    localparam int TCW     = $clog2(TO_CHARS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic flush,
    input  logic tick,
    output logic fire
);
    typedef struct packed {
        logic           armed;
        logic [TCW-1:0] cnt;
        logic           fire;
    } tmo_t;

    tmo_t t_d, t_q;

    always_comb begin
        t_d      = t_q;
        t_d.fire = 1'b0;
        if (flush) begin
            t_d.armed = 1'b0;
            t_d.cnt   = '0;
        end else if (restart) begin
            t_d.armed = 1'b1;
            t_d.cnt   = '0;
        end else if (t_q.armed && tick) begin
            if (t_q.cnt == TCW'(TO_CHARS - 1)) begin
                t_d.fire  = 1'b1;
                t_d.armed = 1'b0;
                t_d.cnt   = '0;
            end else begin
                t_d.cnt = t_q.cnt + TCW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign fire = t_q.fire;
endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int DEPTH    = RXQ_DEPTH,
    parameter int DW       = RXQ_DW,
    parameter int LVLW     = RXQ_LVLW,
    parameter int TO_CHARS = RXQ_TO_CHARS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_en,
    input  logic            rx_dis,
    input  logic            rx_flush,
    input  logic            char_tick,
    input  logic [LVLW-1:0] trig_level,
    input  logic            push_valid,
    input  logic [DW-1:0]   push_data,
    input  logic            pop,
    output logic [DW-1:0]   rd_data,
    output logic            empty,
    output logic            full,
    output logic            trig,
    output logic            overrun,
    output logic            timeout
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [DW-1:0] rd;
        logic          emp;
        logic          ful;
        logic          trg;
        logic          ovr;
    } st_t;

    st_t     s_d, s_q;
    rxq_op_e op;
    logic    rx_on;
    logic    we;
    logic    restart;
    logic [DW-1:0] head;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        rx_on   = rx_en & ~rx_dis;
        op      = rxq_op_e'({rx_on & push_valid, rx_on & pop});
        s_d     = s_q;
        s_d.ovr = 1'b0;
        we      = 1'b0;
        restart = 1'b0;
        if (rx_flush) begin
            s_d.cnt = '0;
            s_d.wp  = '0;
            s_d.rp  = '0;
            s_d.emp = 1'b1;
            s_d.ful = 1'b0;
            s_d.trg = (trig_level == '0);
        end else begin
            unique case (op)
                OP_POP: begin
                    if (s_q.cnt != '0) begin
                        s_d.rd  = head;
                        s_d.rp  = nxt(s_q.rp);
                        s_d.cnt = s_q.cnt - CW'(1);
                    end else begin
                        s_d.rd = '0;
                    end
                end
                OP_PUSH: begin
                    if (s_q.cnt == CW'(DEPTH)) begin
                        s_d.ovr = 1'b1;
                    end else begin
                        we      = 1'b1;
                        restart = 1'b1;
                        s_d.wp  = nxt(s_q.wp);
                        s_d.cnt = s_q.cnt + CW'(1);
                    end
                end
                OP_BOTH: begin
                    we      = 1'b1;
                    restart = 1'b1;
                    s_d.wp  = nxt(s_q.wp);
                    if (s_q.cnt == '0) begin
                        s_d.rd  = '0;
                        s_d.cnt = CW'(1);
                    end else begin
                        s_d.rd = head;
                        s_d.rp = nxt(s_q.rp);
                    end
                end
                default: ;
            endcase
            if (op != OP_IDLE) begin
                s_d.emp = (s_d.cnt == '0);
                s_d.ful = (s_d.cnt == CW'(DEPTH));
                s_d.trg = (int'(s_d.cnt) >= int'(trig_level));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.emp <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    rxq_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
        .clk   (clk),
        .we    (we),
        .waddr (s_q.wp),
        .wdata (push_data),
        .raddr (s_q.rp),
        .rdata (head)
    );

    rxq_tmo #(.TO_CHARS(TO_CHARS)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .flush   (rx_flush),
        .tick    (char_tick),
        .fire    (timeout)
    );

    assign rd_data = s_q.rd;
    assign empty   = s_q.emp;
    assign full    = s_q.ful;
    assign trig    = s_q.trg;
    assign overrun = s_q.ovr;
endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_en,
    input logic          rx_dis,
    input logic          rx_flush,
    input logic          pop,
    input logic [DW-1:0] rd_data,
    input logic          empty,
    input logic          full,
    input logic          overrun,
    input logic          timeout
);
    // R4
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R2
    overrun_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> $past(full));

    // R8
    timeout_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);

    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> (empty && !full));

    // R6
    empty_pop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && !rx_dis && !rx_flush && pop && empty) |=> (rd_data == '0 && !full));

    // R7
    blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_dis && !rx_flush) |=> ($stable(empty) && $stable(full) && $stable(rd_data)));
endmodule

bind rxq_top rxq_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (rx_en),
    .rx_dis   (rx_dis),
    .rx_flush (rx_flush),
    .pop      (pop),
    .rd_data  (rd_data),
    .empty    (empty),
    .full     (full),
    .overrun  (overrun),
    .timeout  (timeout)
);

// File: tb/rxq_top_tb.sv
module rxq_top_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0, rx_dis = 1'b0, rx_flush = 1'b0, char_tick = 1'b0;
    logic [5:0] trig_level = 6'd32;
    logic       push_valid = 1'b0, pop = 1'b0;
    logic [7:0] push_data = 8'h00;
    logic [7:0] rd_data;
    logic       empty, full, trig, overrun, timeout;

    int checks = 0;
    int errors = 0;

    // reference model state
    byte unsigned q[$];
    int  m_rd = 0, m_emp = 1, m_ful = 0, m_trg = 0, m_ovr = 0, m_to = 0;
    int  m_armed = 0, m_tcnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxq_top u_dut (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_dis(rx_dis),
        .rx_flush(rx_flush), .char_tick(char_tick), .trig_level(trig_level),
        .push_valid(push_valid), .push_data(push_data), .pop(pop),
        .rd_data(rd_data), .empty(empty), .full(full), .trig(trig),
        .overrun(overrun), .timeout(timeout)
    );

    task automatic cmp(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    task automatic compare_all();
        cmp("R1 R6 rd_data", int'(rd_data), m_rd);
        cmp("R5 empty", int'(empty), m_emp);
        cmp("R4 full", int'(full), m_ful);
        cmp("R3 trig", int'(trig), m_trg);
        cmp("R2 overrun", int'(overrun), m_ovr);
        cmp("R8 timeout", int'(timeout), m_to);
    endtask

    task automatic model_step();
        int on, dpush, dpop, stored;
        m_ovr = 0; m_to = 0; stored = 0;
        on = (rx_en && !rx_dis);
        if (rx_flush) begin
            q.delete();
            m_emp = 1; m_ful = 0; m_trg = (0 >= int'(trig_level));
            m_armed = 0; m_tcnt = 0;
        end else begin
            dpush = on && push_valid;
            dpop  = on && pop;
            if (dpop) m_rd = (q.size() > 0) ? int'(q.pop_front()) : 0;
            if (dpush) begin
                if (q.size() < 16) begin q.push_back(push_data); stored = 1; end
                else m_ovr = 1;
            end
            if (dpush || dpop) begin
                m_emp = (q.size() == 0);
                m_ful = (q.size() == 16);
                m_trg = (q.size() >= int'(trig_level));
            end
            if (stored) begin
                m_armed = 1; m_tcnt = 0;
            end else if (m_armed && char_tick) begin
                if (m_tcnt == 3) begin m_to = 1; m_armed = 0; m_tcnt = 0; end
                else m_tcnt++;
            end
        end
    endtask

    // drive one cycle, update model at the edge, compare shortly after
    task automatic cyc(input logic p, input logic [7:0] d, input logic o, input logic t);
        push_valid = p; push_data = d; pop = o; char_tick = t;
        @(posedge clk);
        model_step();
        #1;
        compare_all();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL R8 watchdog: actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        compare_all();
        @(posedge clk); #1;
        rx_en = 1'b1;

        // R1: ordered return
        cyc(1, 8'hA1, 0, 0);
        cyc(1, 8'hB2, 0, 0);
        cyc(1, 8'hC3, 0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 8'h00, 1, 0);
        // R6: pop on empty returns zero
        cyc(0, 8'h00, 1, 0);

        // R2 R4 R10: fill to 16 with threshold 32, then overflow
        for (int i = 0; i < 16; i++) cyc(1, 8'(8'h10 + i), 0, 0);
        cyc(1, 8'hEE, 0, 0);
        cyc(1, 8'hEF, 0, 0);
        // R11: push+pop on full: no overrun, stays full
        cyc(1, 8'h77, 1, 0);
        // R4: lone pop clears full
        cyc(0, 8'h00, 1, 0);
        for (int i = 0; i < 16; i++) cyc(0, 8'h00, 1, 0);

        // R3: threshold 4
        trig_level = 6'd4;
        for (int i = 0; i < 5; i++) cyc(1, 8'(8'h40 + i), 0, 0);
        cyc(0, 8'h00, 1, 0);
        cyc(0, 8'h00, 1, 0);

        // R7: block dominates, enable off
        rx_dis = 1'b1;
        cyc(1, 8'h99, 1, 0);
        rx_en = 1'b0;
        cyc(1, 8'h98, 1, 0);
        rx_dis = 1'b0;
        cyc(1, 8'h97, 1, 0);
        rx_en = 1'b1;
        cyc(0, 8'h00, 1, 0);

        // R9: flush with concurrent push/pop ignored
        rx_flush = 1'b1;
        cyc(1, 8'h55, 1, 0);
        rx_flush = 1'b0;
        cyc(0, 8'h00, 1, 0);

        // R11: push+pop on empty
        cyc(1, 8'h61, 1, 0);
        cyc(1, 8'h62, 1, 0);

        // R8: timeout after four ticks
        cyc(1, 8'h70, 0, 0);
        for (int i = 0; i < 4; i++) begin cyc(0, 8'h00, 0, 1); cyc(0, 8'h00, 0, 0); end
        cyc(0, 8'h00, 0, 1);
        // R8: restart coinciding with the fourth tick
        cyc(1, 8'h71, 0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 8'h00, 0, 1);
        cyc(1, 8'h72, 0, 1);
        for (int i = 0; i < 5; i++) cyc(0, 8'h00, 0, 1);
        // R9: flush stops timer
        cyc(1, 8'h73, 0, 0);
        rx_flush = 1'b1; cyc(0, 8'h00, 0, 1); rx_flush = 1'b0;
        for (int i = 0; i < 5; i++) cyc(0, 8'h00, 0, 1);

        // mixed pseudo-random phase
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rx_flush   = (lfsr[4:0] == 5'd0);
            rx_dis     = (lfsr[8:5] == 4'd3);
            rx_en      = (lfsr[11:9] != 3'd0);
            trig_level = (i % 500 == 0) ? 6'(lfsr[4:0] % 20) : trig_level;
            cyc(lfsr[0] | lfsr[12], lfsr[15:8], lfsr[2] & lfsr[14], lfsr[6] & lfsr[3]);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule